// File: doc/BRIEF.md
# ADC Conversion DMA Request Generator

This block sits beside an ADC's conversion sequencer. Each time a conversion finishes, the sequencer pulses a done strobe together with the channel index. If that channel's DMA select bit is set and the global DMA enable is high, the block raises a registered DMA request. It also presents the channel number, so that the DMA controller knows which data register to fetch.

A request stays up until it is cleared. A control bit picks the clear source. In one mode the bus read of that channel's data register clears it. In the other mode a dedicated acknowledge input clears it. Completions that arrive while a request is outstanding wait in a small in-order queue. When the global enable drops, the pending request and the whole queue are discarded.

The per-channel select mask can be written only while the sequencer reports that no conversion is running. A write during a conversion leaves the mask as it was.

Top module: `adc_dma_req`

## Requirements
- R1: After reset, `dma_req` is 0, `dma_ch` is 0 and `dma_sel` (the select mask) is all zeros.
- R2: When enabled with no request outstanding, a `conv_done` pulse on channel c whose bit c of `dma_sel` is 1 makes `dma_req` 1 and `dma_ch` equal to c on the following cycle. A pulse on a channel whose select bit is 0 raises no request.
- R3: While `cfg_dma_en` is 0, no request is raised. Dropping `cfg_dma_en` clears `dma_req` on the next cycle and empties the queue, so re-enabling does not bring back any earlier request.
- R4: A `mask_wr` pulse loads `mask_wdata` into `dma_sel` on the next cycle when `conv_busy` is 0. When `conv_busy` is 1, the write is ignored.
- R5: With `cfg_clr_on_read` = 1, a read (`rd_en`) at address DATA_BASE + c*ADDR_STRIDE, where c is the current `dma_ch`, clears the request on the next cycle. Reads at other addresses have no effect, and `dma_ack` has no effect.
- R6: With `cfg_clr_on_read` = 0, `dma_ack` clears the request on the next cycle. Reads have no effect.
- R7: An eligible completion that arrives while a request is outstanding is queued, up to QDEPTH (default 4) entries. Queued channels are presented in arrival order: the cycle after a clear, `dma_req` stays 1 and `dma_ch` shows the oldest queued channel.
- R8: An eligible completion that arrives while a request is outstanding and the queue is full is dropped.
- R9: If a clear and an eligible completion happen in the same cycle and the queue is empty, the next cycle shows `dma_req` = 1 with the new channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dma_en | input | 1 | Global DMA enable |
| cfg_clr_on_read | input | 1 | 1: data-register read clears; 0: acknowledge clears |
| conv_busy | input | 1 | Conversions active; locks the select mask |
| mask_wr | input | 1 | Select mask write strobe |
| mask_wdata | input | NCH | New select mask |
| conv_done | input | 1 | Conversion complete strobe |
| conv_ch | input | CH_W | Channel of completed conversion |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read address |
| dma_ack | input | 1 | DMA acknowledge |
| dma_req | output | 1 | DMA request |
| dma_ch | output | CH_W | Channel of the request |
| dma_sel | output | NCH | Current select mask |

## Verification
Assertions check the following on every cycle: the one-cycle request latency for an idle, eligible completion; that the request is quiet while disabled; that the mask is frozen during busy writes; that the request and channel hold when there is no clear; that an address matches at most one channel; and that the queue never overflows or underflows. Only the bench's scenarios can show the rest. That covers the arrival order of queued channels and the dropping of the fifth backlog entry. It also covers that wrong-address reads and off-mode acknowledges leave the request untouched, and that re-enabling after a flush yields no stale request.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
   typedef enum logic {
      CLR_BY_ACK  = 1'b0,
      CLR_BY_READ = 1'b1
   } clr_src_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dma_sel_mask.sv
module dma_sel_mask #(
   parameter int unsigned NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic           busy,
   input  logic [NCH-1:0] wdata,
   output logic [NCH-1:0] mask
);
   logic take;

   assign take = wr & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask <= '0;
      else if (take) mask <= wdata;
   end

   AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && busy) |=> $stable(mask)); // R4
endmodule

// File: rtl/dma_chan_fifo.sv
module dma_chan_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << PW));

   if (DEPTH < 2) begin : g_bad_depth
      $error("dma_chan_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;

   if (POW2) begin : g_wrap_nat
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap_cmp
      assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign dout  = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wp] <= din;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop)); // R8
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R7
endmodule

// File: rtl/dma_clr_detect.sv
module dma_clr_detect #(
   parameter int unsigned NCH         = 8,
   parameter int unsigned CH_W        = 3,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_BASE   = 64,
   parameter int unsigned ADDR_STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_read,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              ack,
   input  logic [CH_W-1:0]   pend_ch,
   output logic              clr_hit
);
   localparam longint unsigned TOP_ADDR =
      longint'(DATA_BASE) + longint'(NCH - 1) * longint'(ADDR_STRIDE);

   if (TOP_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_map
      $error("dma_clr_detect: data register map exceeds address width");
   end
   if (ADDR_STRIDE == 0) begin : g_bad_stride
      $error("dma_clr_detect: ADDR_STRIDE must be nonzero");
   end

   logic [NCH-1:0] hit;
   logic           sel_hit;

   for (genvar c = 0; c < NCH; c++) begin : g_hit
      localparam logic [ADDR_W-1:0] CADDR = ADDR_W'(DATA_BASE + c * ADDR_STRIDE);
      assign hit[c] = rd_en && (rd_addr == CADDR);
   end

   assign sel_hit = (int'(pend_ch) < NCH) ? hit[pend_ch] : 1'b0;
   assign clr_hit = mode_read ? sel_hit : ack;

   AST_ONE_ADDR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)); // R5
endmodule

// File: rtl/adc_dma_req.sv
module adc_dma_req #(
   parameter int unsigned NCH         = 8,
   parameter int unsigned QDEPTH      = 4,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_BASE   = 64,
   parameter int unsigned ADDR_STRIDE = 4,
   parameter int unsigned CH_W        = adc_dma_pkg::idx_width(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dma_en,
   input  logic              cfg_clr_on_read,
   input  logic              conv_busy,
   input  logic              mask_wr,
   input  logic [NCH-1:0]    mask_wdata,
   input  logic              conv_done,
   input  logic [CH_W-1:0]   conv_ch,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              dma_ack,
   output logic              dma_req,
   output logic [CH_W-1:0]   dma_ch,
   output logic [NCH-1:0]    dma_sel
);
   import adc_dma_pkg::*;

   if (NCH < 1) begin : g_bad_nch
      $error("adc_dma_req: NCH must be at least 1");
   end
   if (CH_W < adc_dma_pkg::idx_width(NCH)) begin : g_bad_chw
      $error("adc_dma_req: CH_W too narrow for NCH");
   end

   clr_src_e       clr_src;
   logic           req_q, req_d;
   logic [CH_W-1:0] ch_q, ch_d;
   logic           ch_ok, new_ev, clr_hit, clr, slot_free;
   logic           q_push, q_pop, q_empty, q_full, direct;
   logic [CH_W-1:0] q_dout;

   assign clr_src = cfg_clr_on_read ? CLR_BY_READ : CLR_BY_ACK;

   dma_sel_mask #(.NCH(NCH)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (mask_wr),
      .busy  (conv_busy),
      .wdata (mask_wdata),
      .mask  (dma_sel)
   );

   dma_clr_detect #(
      .NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W),
      .DATA_BASE(DATA_BASE), .ADDR_STRIDE(ADDR_STRIDE)
   ) u_clr (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_read (clr_src == CLR_BY_READ),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .ack       (dma_ack),
      .pend_ch   (ch_q),
      .clr_hit   (clr_hit)
   );

   dma_chan_fifo #(.DEPTH(QDEPTH), .W(CH_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!cfg_dma_en),
      .push  (q_push),
      .din   (conv_ch),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   always_comb begin
      ch_ok     = int'(conv_ch) < NCH;
      new_ev    = cfg_dma_en && conv_done && ch_ok && dma_sel[conv_ch];
      clr       = req_q && clr_hit;
      slot_free = !req_q || clr;
      q_pop     = cfg_dma_en && slot_free && !q_empty;
      direct    = new_ev && slot_free && q_empty;
      q_push    = new_ev && !direct && (!q_full || q_pop);

      if (!cfg_dma_en)    req_d = 1'b0;
      else if (slot_free) req_d = !q_empty || new_ev;
      else                req_d = 1'b1;

      if (q_pop)       ch_d = q_dout;
      else if (direct) ch_d = conv_ch;
      else             ch_d = ch_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         ch_q  <= '0;
      end else begin
         req_q <= req_d;
         ch_q  <= ch_d;
      end
   end

   assign dma_req = req_q;
   assign dma_ch  = ch_q;

   AST_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dma_en && conv_done && ch_ok && dma_sel[conv_ch] && !dma_req)
      |=> (dma_req && dma_ch == $past(conv_ch))); // R2
   AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_dma_en |=> !dma_req); // R3
   AST_HOLD_UNCLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dma_en && dma_req && !clr_hit) |=> (dma_req && $stable(dma_ch))); // R6
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dma_en && dma_req && clr_hit && q_empty && !conv_done) |=> !dma_req); // R5
endmodule

// File: tb/adc_dma_req_bench.sv
`timescale 1ns/1ps
module adc_dma_req_bench;
   localparam int NCH = 8, QD = 4, AW = 8, BASE = 64, STR = 4, CW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 0, cor = 0, busy = 0, mwr = 0, done = 0, rd = 0, ack = 0;
   logic [NCH-1:0] mwd = '0;
   logic [CW-1:0]  cch = '0;
   logic [AW-1:0]  raddr = '0;
   logic           req;
   logic [CW-1:0]  dch;
   logic [NCH-1:0] sel;

   int checks = 0, errors = 0;
   string tag = "R1";

   logic [NCH-1:0] e_mask = '0;
   logic           e_req = 0;
   int             e_ch = 0;
   int             q[QD];
   int             qn = 0;

   always #2.5 clk = ~clk;

   adc_dma_req #(.NCH(NCH), .QDEPTH(QD), .ADDR_W(AW), .DATA_BASE(BASE),
                 .ADDR_STRIDE(STR)) u_adc_dma_req (
      .clk(clk), .rst_n(rst_n), .cfg_dma_en(en), .cfg_clr_on_read(cor),
      .conv_busy(busy), .mask_wr(mwr), .mask_wdata(mwd), .conv_done(done),
      .conv_ch(cch), .rd_en(rd), .rd_addr(raddr), .dma_ack(ack),
      .dma_req(req), .dma_ch(dch), .dma_sel(sel));

   task automatic chk(input string r, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   function automatic int daddr(input int c);
      return BASE + c * STR;
   endfunction

   // Expected behaviour per cycle, derived from R2..R9
   task automatic step();
      bit nw, clr, fr;
      @(posedge clk);
      nw = en && done && e_mask[cch];
      if (!en) begin
         e_req = 0; qn = 0;
      end else begin
         clr = e_req && (cor ? (rd && int'(raddr) == daddr(e_ch)) : ack);
         fr  = !e_req || clr;
         if (fr && qn > 0) begin
            e_ch = q[0];
            for (int i = 0; i < QD - 1; i++) q[i] = q[i+1];
            qn--; e_req = 1;
         end else if (fr && nw) begin
            e_ch = cch; e_req = 1; nw = 0;
         end else if (fr) e_req = 0;
         if (nw && qn < QD) begin q[qn] = cch; qn++; end
      end
      if (mwr && !busy) e_mask = mwd;
      #1;
      chk(tag, "dma_req", req, e_req);
      if (e_req) chk(tag, "dma_ch", dch, e_ch);
      chk(tag, "dma_sel", sel, e_mask);
   endtask

   task automatic idle();
      done = 0; rd = 0; ack = 0; mwr = 0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #12 rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1", "dma_req", req, 0);
      chk("R1", "dma_ch", dch, 0);
      chk("R1", "dma_sel", sel, 0);

      // R4: write during busy ignored, then accepted
      tag = "R4"; busy = 1; mwr = 1; mwd = 8'hFF; step();
      idle(); step();
      busy = 0; mwr = 1; mwd = 8'hA5; step();
      idle(); step();

      // R2: sweep every channel under two complementary masks
      tag = "R2"; en = 1;
      for (int m = 0; m < 2; m++) begin
         if (m == 1) begin mwr = 1; mwd = 8'h5A; step(); idle(); end
         for (int c = 0; c < NCH; c++) begin
            done = 1; cch = CW'(c); step();
            idle(); step();
            ack = 1; step();
            idle(); step();
         end
      end

      // R3: disabled completions and flush
      tag = "R3"; mwr = 1; mwd = 8'hFF; step(); idle();
      en = 0; done = 1; cch = 3; step(); idle(); step();
      en = 1;
      for (int c = 0; c < 3; c++) begin done = 1; cch = CW'(c); step(); end
      idle(); en = 0; step(); step();
      en = 1; step(); step();

      // R7 and R8: fill the queue and overflow
      tag = "R8";
      for (int c = 1; c <= 6; c++) begin done = 1; cch = CW'(c); step(); end
      idle(); step();
      tag = "R7";
      for (int k = 0; k < 6; k++) begin ack = 1; step(); idle(); step(); end

      // R9: clear coincides with new completion
      tag = "R9";
      done = 1; cch = 2; step(); idle(); step();
      ack = 1; done = 1; cch = 7; step(); idle(); step();
      ack = 1; step(); idle(); step();

      // R5: clear by data register read
      tag = "R5"; cor = 1;
      for (int c = 0; c < NCH; c++) begin
         done = 1; cch = CW'(c); step(); idle();
         rd = 1; raddr = AW'(daddr((c + 1) % NCH)); step(); idle();
         ack = 1; step(); idle();
         rd = 1; raddr = AW'(daddr(c) + 1); step(); idle();
         rd = 1; raddr = AW'(daddr(c)); step(); idle(); step();
      end

      // R6: acknowledge mode ignores reads
      tag = "R6"; cor = 0;
      done = 1; cch = 5; step(); idle();
      rd = 1; raddr = AW'(daddr(5)); step(); idle(); step();
      ack = 1; step(); idle(); step();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule